// File: doc/BRIEF.md
# Letterbox Bar Line Meter

This block measures the dark bars that a letterboxed picture leaves above and below its image. It watches a luma sample stream one line at a time. Each line is classified black or non-black from the brightest sample inside a programmable central window of the active part of the line. Bright content near the left or right edge, such as a channel logo sitting in a bar, therefore does not break a bar. Bright content in the middle of a line, such as a subtitle placed inside the lower bar, does break it.

For every field the block counts the black lines that open the field and the black lines that close it. When the next field starts, it folds these two counts into running minima that are kept across fields. A controller outside the block reads the minima and works out the zoom. A flag marks a field in which the bars and the picture cannot be told apart, which is a dark, low-contrast scene. A clear pulse drops the stored minima so that measurement starts again.

Samples arrive with `lineActive` high for each active sample of a line. A line ends on the first cycle that `lineActive` is low. `fieldStart` is a one-cycle pulse that closes the field in progress. It must arrive at least one cycle after the last line of that field has ended.

Top module: `letterbox_meter`

## Requirements
- R1: After reset, `statusValid`, `darkPicture`, `minTop` and `minBottom` are all 0.
- R2: A line is black when the largest `lumaIn` among its active samples at positions `winFirst` to `winLast` inclusive is strictly below `blackThresh`. Positions count from 0 at the first active sample of the line. Samples outside that window have no effect on the class.
- R3: The top count of a field is the number of black lines from the first line of the field up to, but not including, the first non-black line.
- R4: The bottom count of a field is the length of the run of black lines that ends with the last line of the field. Any non-black line, such as a subtitle line, restarts that run at zero.
- R5: The outputs change only in the cycle after a `fieldStart` or a `clearMin` pulse. A `fieldStart` that closes a field with no lines leaves every output unchanged.
- R6: When a field that has lines is closed and no minima are stored, its top and bottom counts are stored as they are and `statusValid` goes to 1. When minima are already stored, each stored minimum becomes the smaller of itself and the new count.
- R7: When a field is closed, `darkPicture` becomes 1 if that field's top count plus its bottom count is at least its number of lines, and 0 otherwise.
- R8: A `clearMin` pulse sets `statusValid`, `darkPicture`, `minTop` and `minBottom` to 0 in the next cycle. A field closed in the same cycle as the clear is discarded, and the next field that is closed afterwards is stored as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lumaIn | input | LUMA_W | Luma sample |
| lineActive | input | 1 | High for each active-video sample of a line |
| fieldStart | input | 1 | One-cycle pulse that closes the current field |
| blackThresh | input | LUMA_W | A line is black if its window peak is below this |
| winFirst | input | POS_W | First sample position of the measuring window |
| winLast | input | POS_W | Last sample position of the measuring window |
| clearMin | input | 1 | One-cycle pulse that drops the stored minima |
| minTop | output | CNT_W | Held minimum of the top black-line count |
| minBottom | output | CNT_W | Held minimum of the bottom black-line count |
| darkPicture | output | 1 | Last closed field looked entirely dark |
| statusValid | output | 1 | Minima hold at least one field's result |

## Verification
The hardest cases to reach from the ports are the boundaries of the minimum logic and of the window. These are a later field that lowers only one of the two minima, a clear that arrives in the same cycle as a field close, and a line whose only bright sample sits exactly on the window edge or is exactly at the threshold. Directed fields cover these cases. They use logo lines, subtitle lines and single-sample probe lines with chosen values. Randomly built fields then follow, with random window and threshold settings. The bench tracks every line's expected class from the samples it sends, so the stored minima are checked against an independent model.

// File: rtl/lbm_pkg.sv
`timescale 1ns/1ps
package lbm_pkg;
  // Strobes the control sends to the datapath each cycle
  typedef struct packed {
    logic sampleEn;    // current sample lies inside the measuring window
    logic lineDone;    // the line that just ended is to be classified
    logic fieldReset;  // start a fresh field
    logic fieldCommit; // fold the closed field into the held minima
    logic clearHeld;   // drop the held minima
  } lbm_strobe_t;
endpackage

// File: rtl/lbm_control.sv
`timescale 1ns/1ps
module lbm_control
  import lbm_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineActive,
  input  logic             fieldStart,
  input  logic             clearMin,
  input  logic [POS_W-1:0] winFirst,
  input  logic [POS_W-1:0] winLast,
  output lbm_strobe_t      strobe
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             prevActive;
  logic [POS_W-1:0] pixPos;
  logic             inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      pixPos     <= '0;
    end else begin
      prevActive <= lineActive;
      if (!lineActive) begin
        pixPos <= '0;
      end else if (pixPos != POS_MAX) begin
        pixPos <= pixPos + 1'b1;
      end
    end
  end

  assign inWindow = (pixPos >= winFirst) && (pixPos <= winLast);

  always_comb begin
    strobe.sampleEn    = lineActive && inWindow;
    strobe.lineDone    = prevActive && !lineActive;
    strobe.fieldReset  = fieldStart;
    strobe.clearHeld   = clearMin;
    strobe.fieldCommit = fieldStart && !clearMin;
  end
endmodule

// File: rtl/lbm_datapath.sv
`timescale 1ns/1ps
module lbm_datapath
  import lbm_pkg::*;
#(
  parameter int LUMA_W = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  lbm_strobe_t       strobe,
  input  logic [LUMA_W-1:0] lumaIn,
  input  logic [LUMA_W-1:0] blackThresh,
  output logic [CNT_W-1:0]  minTop,
  output logic [CNT_W-1:0]  minBottom,
  output logic              darkPicture,
  output logic              statusValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LUMA_W-1:0] peakLuma;
  logic              lineBlack;
  logic [CNT_W-1:0]  topCnt;
  logic              topOpen;
  logic [CNT_W-1:0]  botRun;
  logic [CNT_W-1:0]  lineCnt;
  logic [CNT_W:0]    barSum;
  logic [CNT_W-1:0]  nextTop;
  logic [CNT_W-1:0]  nextBottom;

  assign lineBlack = peakLuma < blackThresh;

  // peak luma inside the window of the current line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peakLuma <= '0;
    end else if (strobe.lineDone || strobe.fieldReset) begin
      peakLuma <= '0;
    end else if (strobe.sampleEn && (lumaIn > peakLuma)) begin
      peakLuma <= lumaIn;
    end
  end

  // per-field run counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topCnt  <= '0;
      topOpen <= 1'b1;
      botRun  <= '0;
      lineCnt <= '0;
    end else if (strobe.fieldReset) begin
      topCnt  <= '0;
      topOpen <= 1'b1;
      botRun  <= '0;
      lineCnt <= '0;
    end else if (strobe.lineDone) begin
      if (lineCnt != CNT_MAX) lineCnt <= lineCnt + 1'b1;
      if (lineBlack) begin
        if (botRun != CNT_MAX) botRun <= botRun + 1'b1;
        if (topOpen && (topCnt != CNT_MAX)) topCnt <= topCnt + 1'b1;
      end else begin
        botRun  <= '0;
        topOpen <= 1'b0;
      end
    end
  end

  assign barSum     = {1'b0, topCnt} + {1'b0, botRun};
  assign nextTop    = (!statusValid || (topCnt < minTop))    ? topCnt : minTop;
  assign nextBottom = (!statusValid || (botRun < minBottom)) ? botRun : minBottom;

  // held results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minTop      <= '0;
      minBottom   <= '0;
      darkPicture <= 1'b0;
      statusValid <= 1'b0;
    end else if (strobe.clearHeld) begin
      minTop      <= '0;
      minBottom   <= '0;
      darkPicture <= 1'b0;
      statusValid <= 1'b0;
    end else if (strobe.fieldCommit && (lineCnt != '0)) begin
      minTop      <= nextTop;
      minBottom   <= nextBottom;
      darkPicture <= barSum >= {1'b0, lineCnt};
      statusValid <= 1'b1;
    end
  end
endmodule

// File: rtl/letterbox_meter.sv
`timescale 1ns/1ps
module letterbox_meter
  import lbm_pkg::*;
#(
  parameter int LUMA_W = 8,
  parameter int POS_W  = 11,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LUMA_W-1:0] lumaIn,
  input  logic              lineActive,
  input  logic              fieldStart,
  input  logic [LUMA_W-1:0] blackThresh,
  input  logic [POS_W-1:0]  winFirst,
  input  logic [POS_W-1:0]  winLast,
  input  logic              clearMin,
  output logic [CNT_W-1:0]  minTop,
  output logic [CNT_W-1:0]  minBottom,
  output logic              darkPicture,
  output logic              statusValid
);
  lbm_strobe_t strobe;

  lbm_control #(.POS_W(POS_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .lineActive (lineActive),
    .fieldStart (fieldStart),
    .clearMin   (clearMin),
    .winFirst   (winFirst),
    .winLast    (winLast),
    .strobe     (strobe)
  );

  lbm_datapath #(.LUMA_W(LUMA_W), .CNT_W(CNT_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lumaIn      (lumaIn),
    .blackThresh (blackThresh),
    .minTop      (minTop),
    .minBottom   (minBottom),
    .darkPicture (darkPicture),
    .statusValid (statusValid)
  );
endmodule

// File: rtl/lbm_checker.sv
`timescale 1ns/1ps
module lbm_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             fieldStart,
  input logic             clearMin,
  input logic [CNT_W-1:0] minTop,
  input logic [CNT_W-1:0] minBottom,
  input logic             darkPicture,
  input logic             statusValid
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearMin) |-> (!statusValid && !darkPicture && minTop == '0 && minBottom == '0)); // R8

  AST_MIN_NEVER_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && $past(statusValid) && !$past(clearMin))
      |-> (minTop <= $past(minTop) && minBottom <= $past(minBottom))); // R6

  AST_HOLD_BETWEEN_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(fieldStart) && !$past(clearMin))
      |-> ($stable(minTop) && $stable(minBottom) && $stable(darkPicture) && $stable(statusValid))); // R5

  AST_DARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    darkPicture |-> statusValid); // R7
endmodule

bind letterbox_meter lbm_checker #(.CNT_W(CNT_W)) u_lbm_checker (
  .clk         (clk),
  .rstN        (rstN),
  .fieldStart  (fieldStart),
  .clearMin    (clearMin),
  .minTop      (minTop),
  .minBottom   (minBottom),
  .darkPicture (darkPicture),
  .statusValid (statusValid)
);

// File: tb/letterbox_meter_bench.sv
`timescale 1ns/1ps
module letterbox_meter_bench;
  localparam int LW = 8;
  localparam int PW = 11;
  localparam int CW = 10;
  localparam int LINE_LEN = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [LW-1:0] lumaIn = '0;
  logic          lineActive = 1'b0;
  logic          fieldStart = 1'b0;
  logic [LW-1:0] blackThresh = 8'd32;
  logic [PW-1:0] winFirst = 11'd4;
  logic [PW-1:0] winLast = 11'd27;
  logic          clearMin = 1'b0;
  logic [CW-1:0] minTop;
  logic [CW-1:0] minBottom;
  logic          darkPicture;
  logic          statusValid;

  always #2.5 clk = ~clk;

  letterbox_meter u_letterbox_meter (
    .clk(clk), .rstN(rstN), .lumaIn(lumaIn), .lineActive(lineActive),
    .fieldStart(fieldStart), .blackThresh(blackThresh), .winFirst(winFirst),
    .winLast(winLast), .clearMin(clearMin), .minTop(minTop),
    .minBottom(minBottom), .darkPicture(darkPicture), .statusValid(statusValid)
  );

  int checks = 0;
  int fails = 0;
  int probe = 0;
  int eTop = 0, eBot = 0, eN = 0;
  bit eOpen = 1'b1;
  int mT = 0, mB = 0;
  bit mD = 1'b0, mV = 1'b0;
  int seedDummy;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "minTop", int'(minTop), mT);
    check(req, "minBottom", int'(minBottom), mB);
    check(req, "darkPicture", int'(darkPicture), int'(mD));
    check(req, "statusValid", int'(statusValid), int'(mV));
  endtask

  // kinds: 0 black, 1 black with bright edges, 2 black with centre subtitle,
  // 3 picture, 4 single probe sample at position 16, 5 bright only at winFirst
  function automatic int lumaFor(input int kind, input int p);
    case (kind)
      0: return int'($urandom % 16);
      1: return (p < int'(winFirst) || p > int'(winLast)) ? 200 + int'($urandom % 50) : int'($urandom % 16);
      2: return (p >= 12 && p <= 19) ? 180 : int'($urandom % 16);
      3: return 40 + int'($urandom % 200);
      4: return (p == 16) ? probe : 0;
      default: return (p == int'(winFirst)) ? 200 : 0;
    endcase
  endfunction

  task automatic sendLine(input int kind);
    int pk = 0;
    for (int p = 0; p < LINE_LEN; p++) begin
      int v = lumaFor(kind, p);
      @(negedge clk);
      lumaIn = LW'(v);
      lineActive = 1'b1;
      if (p >= int'(winFirst) && p <= int'(winLast) && v > pk) pk = v;
    end
    @(negedge clk);
    lineActive = 1'b0;
    lumaIn = '0;
    @(negedge clk);
    eN++;
    if (pk < int'(blackThresh)) begin
      eBot++;
      if (eOpen) eTop++;
    end else begin
      eBot = 0;
      eOpen = 1'b0;
    end
  endtask

  task automatic sendLines(input int kind, input int n);
    for (int i = 0; i < n; i++) sendLine(kind);
  endtask

  task automatic endField(input bit clr, input string req);
    @(negedge clk);
    fieldStart = 1'b1;
    clearMin = clr;
    @(negedge clk);
    fieldStart = 1'b0;
    clearMin = 1'b0;
    if (clr) begin
      mV = 0; mT = 0; mB = 0; mD = 0;
    end else if (eN > 0) begin
      if (!mV || eTop < mT) mT = eTop;
      if (!mV || eBot < mB) mB = eBot;
      mD = (eTop + eBot) >= eN;
      mV = 1'b1;
    end
    eTop = 0; eBot = 0; eN = 0; eOpen = 1'b1;
    checkAll(req);
  endtask

  task automatic clearOnly(input string req);
    @(negedge clk);
    clearMin = 1'b1;
    @(negedge clk);
    clearMin = 1'b0;
    mV = 0; mT = 0; mB = 0; mD = 0;
    checkAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // logo lines on top, plain black at bottom
    sendLines(1, 5); sendLines(3, 10); sendLines(0, 3);
    endField(1'b0, "R3");
    // a subtitle line breaks the bottom bar, top bar is larger
    sendLines(0, 6); sendLines(3, 8); sendLines(0, 4); sendLine(2); sendLines(0, 2);
    endField(1'b0, "R4");
    // field with no lines leaves everything alone
    endField(1'b0, "R5");
    // every line black: dark picture
    sendLines(0, 8);
    endField(1'b0, "R7");
    // a normal field clears the dark flag, minima stay lower
    sendLines(0, 9); sendLines(3, 4); sendLines(1, 9);
    endField(1'b0, "R6");

    // clear, then the next field is stored as it is
    clearOnly("R8");
    sendLines(0, 7); sendLines(3, 5); sendLines(0, 6);
    endField(1'b0, "R8");
    // a field closed together with a clear is dropped
    sendLines(0, 1); sendLines(3, 3); sendLines(0, 1);
    endField(1'b1, "R8");

    // threshold and window boundaries
    blackThresh = 8'd50;
    probe = 49; sendLines(4, 2);
    probe = 50; sendLine(4);
    sendLine(5);
    probe = 49; sendLine(4);
    endField(1'b0, "R2");

    // random fields with random settings
    for (int f = 0; f < 24; f++) begin
      int nTop, nMid, nBot;
      winFirst = PW'(2 + $urandom % 5);
      winLast = PW'(24 + $urandom % 6);
      blackThresh = LW'(20 + $urandom % 41);
      nTop = int'($urandom % 8);
      nMid = int'($urandom % 10);
      nBot = int'($urandom % 8);
      for (int i = 0; i < nTop; i++) sendLine(int'($urandom % 2));
      for (int i = 0; i < nMid; i++) sendLine(2 + int'($urandom % 2));
      for (int i = 0; i < nBot; i++) sendLine(int'($urandom % 2));
      endField(1'b0, "R6");
      if (($urandom % 8) == 0) clearOnly("R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule